// File: doc/BRIEF.md
# Stripe XOR Parity Engine

This block produces the parity page of a channel stripe and recovers a lost page of that stripe, using a single XOR accumulation datapath for both jobs. A stripe has three data pages and one parity page, so a quarter of the stored capacity holds redundancy. Each page is 8 KB. A page arrives as four 2 KB chunks, and each chunk arrives as a run of fixed-width beats. Every beat carries a page-slot tag and a chunk tag. Slots 0 to 2 are the data pages and slot 3 is the parity page.

In encode mode the engine takes the three data pages, in any order, and streams out their XOR, which is the parity page. In rebuild mode it takes any three distinct slots, parity included, and streams out their XOR, which is the missing page. Each accepted page is folded into an on-chip page buffer at the same beat offset as the earlier pages. The first page of a stripe overwrites the buffer, so no separate clear pass is needed.

The finished page is streamed out as four tagged chunks, and a done flag marks the final beat. Input is held off while the result drains. Beats with a wrong chunk tag, a slot already used in the stripe, or a slot not allowed in the current mode are dropped, and each dropped beat raises an error pulse.

Top module: `stripe_parity_engine`

## Requirements
- R1: While reset is asserted, and straight after it, in_ready is 1, out_valid is 0 and err_pulse is 0.
- R2: In encode mode (in_mode = 0), once slots 0, 1 and 2 have each been delivered in full, in any order, output beat b equals the XOR of beat b of the three data pages.
- R3: In rebuild mode (in_mode = 1), any three distinct slots from 0 to 3 can be delivered, and output beat b equals the XOR of their beat b. This equals beat b of the fourth slot.
- R4: Within a page, beat n must carry chunk tag n / CHUNK_BEATS (0 to 3), and every beat after the first must carry the page's slot tag. A beat that breaks either rule is dropped and causes a one-cycle err_pulse in the next cycle.
- R5: The first beat of a page whose slot was already completed in the current stripe is dropped and raises err_pulse.
- R6: In encode mode, a page starting with slot 3 (the parity slot) is dropped and raises err_pulse.
- R7: out_valid stays 0 until the third page of the stripe has been completely accepted. It then carries exactly PAGE_BEATS beats in address order. out_chunk is the beat index divided by CHUNK_BEATS, and out_last is 1 only on the final beat.
- R8: While out_valid is 1, in_ready is 0. While out_ready is 0, out_data and out_chunk hold their values.
- R9: The mode is taken from the first accepted beat of a stripe. Later changes of in_mode within that stripe have no effect.
- R10: After the last output beat is taken, the engine accepts a new stripe, and the result of that stripe does not depend on any earlier stripe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Engine can take an input beat |
| in_data | input | BEAT_W | Input beat payload |
| in_page | input | PAGE_IDX_W | Stripe slot of the beat (3 = parity) |
| in_chunk | input | CHUNK_IDX_W | Chunk index of the beat within its page |
| in_mode | input | 1 | 0 = encode, 1 = rebuild |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result beat |
| out_data | output | BEAT_W | Result beat payload |
| out_chunk | output | CHUNK_IDX_W | Chunk index of the result beat |
| out_last | output | 1 | Final beat of the result page (done) |
| err_pulse | output | 1 | A beat was dropped in the previous cycle |

## Verification
The bench sweeps all four choices of missing slot in rebuild mode and several delivery orders in encode mode. It checks every output beat against XORs computed from a hashed data pattern, so a buffer that is not overwritten by the first page, or one that mixes offsets, gives wrong words. Bad beats are injected at page starts and in the middle of pages: a duplicate slot, a skipped chunk tag, the parity slot in encode mode, and a mode change after the first beat. A design that accepted any of these would corrupt the result or give the wrong err_pulse count. Random-looking output stalls test that the result holds steady and that input stays blocked, and a result that appears early or that has the wrong length is reported.

// File: rtl/stripe_parity_pkg.sv
package stripe_parity_pkg;
  typedef enum logic {
    MODE_ENCODE  = 1'b0,
    MODE_REBUILD = 1'b1
  } parity_mode_e;
endpackage

// File: rtl/stripe_tracker.sv
module stripe_tracker
  import stripe_parity_pkg::*;
#(
  parameter int NUM_SLOTS   = 4,
  parameter int DATA_PAGES  = 3,
  parameter int CHUNK_BEATS = 256,
  parameter int PAGE_BEATS  = 1024,
  localparam int PAGE_IDX_W  = $clog2(NUM_SLOTS),
  localparam int CHUNK_IDX_W = $clog2(PAGE_BEATS / CHUNK_BEATS),
  localparam int ADDR_W      = $clog2(PAGE_BEATS),
  localparam int CNT_W       = $clog2(DATA_PAGES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   beat_fire,
  input  logic [PAGE_IDX_W-1:0]  beat_page,
  input  logic [CHUNK_IDX_W-1:0] beat_chunk,
  input  logic                   beat_mode,
  input  logic                   restart,
  output logic                   beat_accept,
  output logic [ADDR_W-1:0]      wr_addr,
  output logic                   first_page,
  output logic                   stripe_full,
  output logic                   err_q
);
  localparam logic [PAGE_IDX_W-1:0] PARITY_SLOT = PAGE_IDX_W'(NUM_SLOTS - 1);
  localparam logic [ADDR_W-1:0]     LAST_BEAT   = ADDR_W'(PAGE_BEATS - 1);
  localparam logic [CNT_W-1:0]      LAST_PAGE   = CNT_W'(DATA_PAGES - 1);

  logic [ADDR_W-1:0]     beat_q, beat_d;
  logic [PAGE_IDX_W-1:0] page_q;
  logic                  mid_q, mid_d;
  logic [CNT_W-1:0]      done_q, done_d;
  logic                  full_q, full_d;
  logic                  active_q, active_d;
  logic                  mode_q;
  logic                  err_d;
  logic [NUM_SLOTS-1:0]  seen_q;

  logic [CHUNK_IDX_W-1:0] exp_chunk;
  logic                   mode_eff;
  logic                   chunk_ok, page_ok, parity_blocked;
  logic                   page_end, beat_en, mode_en, page_en;

  always_comb begin
    exp_chunk      = CHUNK_IDX_W'(beat_q / ADDR_W'(CHUNK_BEATS));
    mode_eff       = active_q ? mode_q : beat_mode;
    chunk_ok       = (beat_chunk == exp_chunk);
    parity_blocked = (mode_eff == MODE_ENCODE) && (beat_page == PARITY_SLOT);
    page_ok        = mid_q ? (beat_page == page_q)
                           : (!seen_q[beat_page] && !parity_blocked);
    beat_accept    = beat_fire && !full_q && chunk_ok && page_ok;
    err_d          = beat_fire && !full_q && !(chunk_ok && page_ok);
    page_end       = beat_accept && (beat_q == LAST_BEAT);
  end

  // next-state
  always_comb begin
    beat_en  = restart || beat_accept;
    beat_d   = (restart || page_end) ? '0 : beat_q + 1'b1;
    mid_d    = restart ? 1'b0 : !page_end;
    done_d   = restart ? '0 : done_q + 1'b1;
    full_d   = restart ? 1'b0 : (page_end && (done_q == LAST_PAGE)) ? 1'b1 : full_q;
    active_d = restart ? 1'b0 : (beat_accept ? 1'b1 : active_q);
    mode_en  = beat_accept && !active_q;
    page_en  = beat_accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q   <= '0;
      mid_q    <= 1'b0;
      done_q   <= '0;
      full_q   <= 1'b0;
      active_q <= 1'b0;
      mode_q   <= 1'b0;
      page_q   <= '0;
      err_q    <= 1'b0;
    end else begin
      if (beat_en) begin
        beat_q <= beat_d;
        mid_q  <= mid_d;
      end
      if (restart || page_end) done_q <= done_d;
      full_q   <= full_d;
      active_q <= active_d;
      if (mode_en) mode_q <= beat_mode;
      if (page_en) page_q <= beat_page;
      err_q    <= err_d;
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic set_s;
    assign set_s = page_end && (beat_page == PAGE_IDX_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               seen_q[s] <= 1'b0;
      else if (restart || set_s) seen_q[s] <= !restart;
    end
  end

  assign wr_addr     = beat_q;
  assign first_page  = (done_q == '0);
  assign stripe_full = full_q;
endmodule

// File: rtl/xor_accum_buf.sv
module xor_accum_buf #(
  parameter int BEAT_W = 64,
  parameter int DEPTH  = 1024,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              overwrite,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BEAT_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BEAT_W-1:0] rd_data
);
  logic [BEAT_W-1:0] mem [DEPTH];
  logic [BEAT_W-1:0] fold;

  always_comb begin
    fold    = overwrite ? wr_data : (mem[wr_addr] ^ wr_data);
    rd_data = mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= fold;
  end
endmodule

// File: rtl/result_streamer.sv
module result_streamer #(
  parameter int PAGE_BEATS  = 1024,
  parameter int CHUNK_BEATS = 256,
  localparam int ADDR_W      = $clog2(PAGE_BEATS),
  localparam int CHUNK_IDX_W = $clog2(PAGE_BEATS / CHUNK_BEATS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   result_ready,
  input  logic                   sink_ready,
  output logic [ADDR_W-1:0]      rd_addr,
  output logic [CHUNK_IDX_W-1:0] chunk_tag,
  output logic                   last_beat,
  output logic                   page_sent
);
  localparam logic [ADDR_W-1:0] LAST_BEAT = ADDR_W'(PAGE_BEATS - 1);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              fire, addr_en;

  always_comb begin
    fire      = result_ready && sink_ready;
    last_beat = result_ready && (addr_q == LAST_BEAT);
    page_sent = fire && (addr_q == LAST_BEAT);
    addr_en   = fire;
    addr_d    = page_sent ? '0 : addr_q + 1'b1;
    chunk_tag = CHUNK_IDX_W'(addr_q / ADDR_W'(CHUNK_BEATS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign rd_addr = addr_q;
endmodule

// File: rtl/stripe_parity_engine.sv
module stripe_parity_engine #(
  parameter int BEAT_W          = 64,
  parameter int CHUNK_BEATS     = 256,
  parameter int CHUNKS_PER_PAGE = 4,
  parameter int DATA_PAGES      = 3,
  localparam int NUM_SLOTS   = DATA_PAGES + 1,
  localparam int PAGE_BEATS  = CHUNK_BEATS * CHUNKS_PER_PAGE,
  localparam int PAGE_IDX_W  = $clog2(NUM_SLOTS),
  localparam int CHUNK_IDX_W = $clog2(CHUNKS_PER_PAGE),
  localparam int ADDR_W      = $clog2(PAGE_BEATS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [BEAT_W-1:0]      in_data,
  input  logic [PAGE_IDX_W-1:0]  in_page,
  input  logic [CHUNK_IDX_W-1:0] in_chunk,
  input  logic                   in_mode,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [BEAT_W-1:0]      out_data,
  output logic [CHUNK_IDX_W-1:0] out_chunk,
  output logic                   out_last,
  output logic                   err_pulse
);
  logic              beat_accept, first_page, stripe_full, page_sent;
  logic [ADDR_W-1:0] wr_addr, rd_addr;

  assign in_ready  = !stripe_full;
  assign out_valid = stripe_full;

  stripe_tracker #(
    .NUM_SLOTS  (NUM_SLOTS),
    .DATA_PAGES (DATA_PAGES),
    .CHUNK_BEATS(CHUNK_BEATS),
    .PAGE_BEATS (PAGE_BEATS)
  ) tracker_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_fire  (in_valid && in_ready),
    .beat_page  (in_page),
    .beat_chunk (in_chunk),
    .beat_mode  (in_mode),
    .restart    (page_sent),
    .beat_accept(beat_accept),
    .wr_addr    (wr_addr),
    .first_page (first_page),
    .stripe_full(stripe_full),
    .err_q      (err_pulse)
  );

  xor_accum_buf #(
    .BEAT_W(BEAT_W),
    .DEPTH (PAGE_BEATS)
  ) buf_i (
    .clk      (clk),
    .wr_en    (beat_accept),
    .overwrite(first_page),
    .wr_addr  (wr_addr),
    .wr_data  (in_data),
    .rd_addr  (rd_addr),
    .rd_data  (out_data)
  );

  result_streamer #(
    .PAGE_BEATS (PAGE_BEATS),
    .CHUNK_BEATS(CHUNK_BEATS)
  ) stream_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .result_ready(stripe_full),
    .sink_ready  (out_ready),
    .rd_addr     (rd_addr),
    .chunk_tag   (out_chunk),
    .last_beat   (out_last),
    .page_sent   (page_sent)
  );
endmodule

// File: rtl/stripe_parity_engine_chk.sv
module stripe_parity_engine_chk #(
  parameter int BEAT_W          = 64,
  parameter int CHUNK_BEATS     = 256,
  parameter int CHUNKS_PER_PAGE = 4,
  parameter int DATA_PAGES      = 3,
  localparam int NUM_SLOTS   = DATA_PAGES + 1,
  localparam int PAGE_IDX_W  = $clog2(NUM_SLOTS),
  localparam int CHUNK_IDX_W = $clog2(CHUNKS_PER_PAGE)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic [BEAT_W-1:0]      in_data,
  input logic [PAGE_IDX_W-1:0]  in_page,
  input logic [CHUNK_IDX_W-1:0] in_chunk,
  input logic                   in_mode,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [BEAT_W-1:0]      out_data,
  input logic [CHUNK_IDX_W-1:0] out_chunk,
  input logic                   out_last,
  input logic                   err_pulse
);
  localparam logic [CHUNK_IDX_W-1:0] LAST_CHUNK = CHUNK_IDX_W'(CHUNKS_PER_PAGE - 1);

  assert_err_after_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(in_valid && in_ready));

  assert_result_after_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  assert_last_in_final_chunk_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (out_valid && out_chunk == LAST_CHUNK));

  assert_single_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid);

  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_chunk)));
endmodule

bind stripe_parity_engine stripe_parity_engine_chk #(
  .BEAT_W         (BEAT_W),
  .CHUNK_BEATS    (CHUNK_BEATS),
  .CHUNKS_PER_PAGE(CHUNKS_PER_PAGE),
  .DATA_PAGES     (DATA_PAGES)
) chk_i (.*);

// File: tb/stripe_parity_engine_tb.sv
module stripe_parity_engine_tb_top;
  localparam int BW = 64;
  localparam int CB = 256;
  localparam int NCH = 4;
  localparam int PB = CB * NCH;

  logic          clk, rst_n;
  logic          in_valid, in_ready, in_mode, out_valid, out_ready, out_last, err_pulse;
  logic [BW-1:0] in_data, out_data;
  logic [1:0]    in_page, in_chunk, out_chunk;

  int vectors = 0, miscompares = 0;
  int collected = 0, err_seen = 0, exp_err = 0, cyc = 0;
  int cur_seed = 0, cur_missing = 3;
  bit bp_on = 0, stall_prev = 0;
  logic [BW-1:0] stall_data;

  stripe_parity_engine dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_page(in_page), .in_chunk(in_chunk), .in_mode(in_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_chunk(out_chunk), .out_last(out_last), .err_pulse(err_pulse)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  function automatic logic [BW-1:0] mix(int s, int p, int b);
    logic [BW-1:0] x;
    x = {32'(s), 16'(p), 16'(b)} ^ 64'hA5A5_3C3C_5A5A_C3C3;
    x = x * 64'h9E37_79B9_7F4A_7C15;
    x = x ^ (x >> 31);
    return x;
  endfunction

  function automatic logic [BW-1:0] page_word(int s, int p, int b);
    if (p == 3) return mix(s, 0, b) ^ mix(s, 1, b) ^ mix(s, 2, b);
    return mix(s, p, b);
  endfunction

  task automatic check(bit ok, string req, string what, logic [BW-1:0] act, logic [BW-1:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      out_ready = 1'b1;
      stall_prev = 0;
    end else begin
      cyc++;
      out_ready = bp_on ? ((cyc % 3) != 0) : 1'b1;
      if (stall_prev && out_valid)
        check(out_data == stall_data, "R8", "held data", out_data, stall_data);
      if (out_valid)
        check(!in_ready, "R8", "in_ready during output", BW'(in_ready), 0);
      stall_prev = out_valid && !out_ready;
      stall_data = out_data;
      if (out_valid && out_ready) begin
        check(out_data == page_word(cur_seed, cur_missing, collected),
              (cur_missing == 3) ? "R2" : "R3", "result beat",
              out_data, page_word(cur_seed, cur_missing, collected));
        check(out_chunk == 2'(collected / CB), "R7", "out_chunk", BW'(out_chunk), BW'(collected / CB));
        check(out_last == (collected == PB - 1), "R7", "out_last", BW'(out_last), BW'(collected == PB - 1));
        collected++;
      end
      if (err_pulse) err_seen++;
    end
  end

  task automatic send_beat(int pg, int ch, logic [BW-1:0] d, logic m);
    @(negedge clk);
    in_valid = 1; in_page = 2'(pg); in_chunk = 2'(ch); in_data = d; in_mode = m;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic send_page(int s, int pg, logic m0, logic mr, int inject);
    for (int b = 0; b < PB; b++) begin
      if (b == inject) begin
        send_beat(pg, (b / CB + 2) % NCH, 64'hDEAD_BEEF_0000_0000, mr);
        exp_err++;
      end
      send_beat(pg, b / CB, page_word(s, pg, b), (b == 0) ? m0 : mr);
    end
    idle();
  endtask

  task automatic expect_quiet(string req);
    @(negedge clk);
    check(!out_valid, req, "no early result", BW'(out_valid), 0);
  endtask

  task automatic wait_result(string req);
    while (collected < PB) @(negedge clk);
    repeat (3) @(negedge clk);
    check(collected == PB, "R7", "result length", BW'(collected), BW'(PB));
    check(!out_valid && in_ready, req, "ready for next stripe", BW'({out_valid, in_ready}), 1);
    check(err_seen == exp_err, "R4", "error pulse count", BW'(err_seen), BW'(exp_err));
  endtask

  task automatic stripe(int s, int missing, int p0, int p1, int p2, logic m);
    cur_seed = s; cur_missing = missing; collected = 0;
    send_page(s, p0, m, m, -1); expect_quiet("R7");
    send_page(s, p1, m, m, -1); expect_quiet("R7");
    send_page(s, p2, m, m, -1);
    wait_result("R10");
  endtask

  initial begin
    in_valid = 0; in_data = '0; in_page = '0; in_chunk = '0; in_mode = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(in_ready == 1, "R1", "in_ready in reset", BW'(in_ready), 1);
    check(out_valid == 0, "R1", "out_valid in reset", BW'(out_valid), 0);
    check(err_pulse == 0, "R1", "err_pulse in reset", BW'(err_pulse), 0);
    rst_n = 1;
    @(negedge clk);
    check(in_ready && !out_valid && !err_pulse, "R1", "after reset", BW'({in_ready, out_valid, err_pulse}), 3'b100);

    // R2: encode, natural order then permuted with output stalls (R8)
    stripe(11, 3, 0, 1, 2, 1'b0);
    bp_on = 1;
    stripe(22, 3, 2, 0, 1, 1'b0);
    bp_on = 0;

    // R3: rebuild every missing slot; R10: back-to-back stripes
    for (int m = 0; m < 4; m++) begin
      int a, b, c;
      a = (m + 1) % 4; b = (m + 3) % 4; c = (m + 2) % 4;
      stripe(100 + m, m, a, b, c, 1'b1);
    end

    // R5: duplicate slot rejected (first beats of a repeated page)
    cur_seed = 33; cur_missing = 3; collected = 0;
    send_page(33, 1, 1'b0, 1'b0, -1);
    for (int b = 0; b < 5; b++) begin
      send_beat(1, 0, 64'hFFFF_0000_FFFF_0000, 1'b0);
      exp_err++;
    end
    idle();
    // R4: skipped chunk tag inside a page, and slot change mid-page
    send_page(33, 0, 1'b0, 1'b0, 300);
    send_beat(2, 0, page_word(33, 2, 0), 1'b0);
    for (int b = 1; b < PB; b++) begin
      if (b == 700) begin
        send_beat(1, b / CB, 64'h1234, 1'b0);
        exp_err++;
      end
      send_beat(2, b / CB, page_word(33, 2, b), 1'b0);
    end
    idle();
    wait_result("R5");

    // R6: parity slot refused in encode mode
    cur_seed = 44; cur_missing = 3; collected = 0;
    for (int b = 0; b < 3; b++) begin
      send_beat(3, 0, page_word(44, 3, b), 1'b0);
      exp_err++;
    end
    idle();
    send_page(44, 2, 1'b0, 1'b0, -1);
    send_page(44, 0, 1'b0, 1'b0, -1);
    send_page(44, 1, 1'b0, 1'b0, -1);
    wait_result("R6");

    // R9: rebuild chosen on first beat; later encode-mode requests ignored
    cur_seed = 55; cur_missing = 2; collected = 0;
    send_page(55, 0, 1'b1, 1'b0, -1);
    send_page(55, 3, 1'b0, 1'b0, -1);
    send_page(55, 1, 1'b0, 1'b0, -1);
    wait_result("R9");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(8 * 150000);
    miscompares++;
    vectors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule